// File: doc/BRIEF.md
# Table Pointer Memory Access Unit

This unit carries single bytes between byte-addressed program memory and an 8-bit table latch. The address comes from a 21-bit table pointer. A controller issues one command at a time, either a read (memory byte into the latch) or a write (latch byte out to memory). Each command carries one of four pointer-update modes: leave the pointer alone, bump it after the access, drop it after the access, or bump it before the access and use the bumped address.

The controller can load the pointer and the latch directly from outside while the unit is idle. Toward memory the unit issues a one-cycle request. Address, write enable and write data are held steady until an acknowledge returns. On a read, the data returned with that acknowledge is taken into the latch. A write is only a strobe with an address and a byte; erase and programming timing belong to the memory side.

Top module: `tblx_unit`

## Requirements
- R1: After synchronous reset the pointer and the latch are zero, and `busy`, `mem_req` and `mem_we` are low.
- R2: A command present on `cmd_valid` while `busy` is low is accepted at that clock edge. From the next cycle `busy` is high and `mem_req` is high for exactly one cycle. `mem_addr`, `mem_we` and `mem_wdata` then stay stable until the edge at which `mem_ack` is seen.
- R3: A read (`cmd_write`=0) loads `mem_rdata` into the latch at the edge where `mem_ack` is high. `busy` falls at that same edge.
- R4: A write (`cmd_write`=1) drives `mem_we` high and `mem_wdata` equal to the latch for the whole access. The latch is left unchanged.
- R5: Mode 2'b00 (keep) accesses the pointer address and leaves the pointer unchanged.
- R6: Mode 2'b01 (post-increment) accesses the pointer address. The pointer then becomes the old value plus one at the completing edge.
- R7: Mode 2'b10 (post-decrement) accesses the pointer address. The pointer then becomes the old value minus one at the completing edge.
- R8: Mode 2'b11 (pre-increment) sets the pointer to the old value plus one at the accepting edge and accesses that new address.
- R9: Pointer arithmetic wraps modulo 2^21: 0x1FFFFF plus one is 0, and 0 minus one is 0x1FFFFF.
- R10: `ptr_load` and `lat_load` write their values at the next edge only when `busy` is low and `cmd_valid` is low. They are ignored while busy, and a command in the same cycle takes precedence over them.
- R11: `busy` stays high for any number of cycles until `mem_ack` arrives. During that time the pointer does not change, and new commands and loads are ignored. An `mem_ack` while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_write | input | 1 | 1 = write latch to memory, 0 = read memory into latch |
| cmd_mode | input | 2 | Pointer update mode: 00 keep, 01 post-inc, 10 post-dec, 11 pre-inc |
| ptr_load | input | 1 | Load pointer from `ptr_load_val` |
| ptr_load_val | input | 21 | Pointer load value |
| lat_load | input | 1 | Load latch from `lat_load_val` |
| lat_load_val | input | 8 | Latch load value |
| ptr_o | output | 21 | Current pointer |
| lat_o | output | 8 | Current latch |
| busy | output | 1 | Access in progress |
| mem_req | output | 1 | One-cycle memory request |
| mem_we | output | 1 | Write enable, held for the access |
| mem_addr | output | 21 | Byte address, held for the access |
| mem_wdata | output | 8 | Write data, held for the access |
| mem_rdata | input | 8 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access complete |

## Verification
Call the edge that accepts a command E0. `busy`, `mem_req`, `mem_addr` and, for pre-increment, the new pointer are due in the cycle after E0. The bench samples them at the falling edge that follows E0. The bench's memory model raises `mem_ack` one or more cycles later, and the latch, the post-update pointer and the falling `busy` are due in the cycle after the edge that samples that acknowledge. The bench drives every input and reads every output at falling edges, so each check lands exactly one register stage after its cause.

// File: rtl/tblx_pkg.sv
package tblx_pkg;
    localparam int ADDR_W = 21;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        UPD_KEEP    = 2'b00,
        UPD_POSTINC = 2'b01,
        UPD_POSTDEC = 2'b10,
        UPD_PREINC  = 2'b11
    } upd_mode_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'b00,
        SQ_ISSUE = 2'b01,
        SQ_WAIT  = 2'b10
    } sq_state_e;

    typedef struct packed {
        logic      write;
        upd_mode_e mode;
    } cmd_t;

    // Step a pointer by +1, -1 or 0 with natural modulo wrap.
    function automatic logic [ADDR_W-1:0] step_ptr(input logic [ADDR_W-1:0] p,
                                                   input logic up, input logic down);
        logic [ADDR_W-1:0] r;
        r = p;
        if (up)        r = p + ADDR_W'(1);
        else if (down) r = p - ADDR_W'(1);
        return r;
    endfunction
endpackage

// File: rtl/tblx_seq.sv
module tblx_seq
    import tblx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmd_valid,
    input  logic cmd_write,
    input  logic [1:0] cmd_mode,
    input  logic mem_ack,
    output logic accept,
    output logic done,
    output logic busy,
    output logic issue,
    output cmd_t cmd_q
);
    sq_state_e state_q, state_d;

    always_comb begin
        accept  = (state_q == SQ_IDLE) && cmd_valid;
        busy    = (state_q != SQ_IDLE);
        issue   = (state_q == SQ_ISSUE);
        done    = busy && mem_ack;
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:  if (accept) state_d = SQ_ISSUE;
            SQ_ISSUE: state_d = mem_ack ? SQ_IDLE : SQ_WAIT;
            SQ_WAIT:  if (mem_ack) state_d = SQ_IDLE;
            default:  state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            cmd_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cmd_q.write <= cmd_write;
                cmd_q.mode  <= upd_mode_e'(cmd_mode);
            end
        end
    end
endmodule

// File: rtl/tblx_ptr.sv
module tblx_ptr
    import tblx_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic [1:0]    acc_mode,
    input  logic          done,
    input  upd_mode_e     held_mode,
    input  logic          load_en,
    input  logic [AW-1:0] load_val,
    output logic [AW-1:0] ptr_q,
    output logic [AW-1:0] addr_q
);
    logic          pre_inc;
    logic [AW-1:0] ptr_d, addr_d;

    always_comb begin
        pre_inc = accept && (upd_mode_e'(acc_mode) == UPD_PREINC);
        ptr_d   = ptr_q;
        addr_d  = addr_q;
        if (accept) begin
            ptr_d  = AW'(step_ptr(ADDR_W'(ptr_q), pre_inc, 1'b0));
            addr_d = ptr_d;
        end else if (done) begin
            ptr_d = AW'(step_ptr(ADDR_W'(ptr_q),
                                 held_mode == UPD_POSTINC,
                                 held_mode == UPD_POSTDEC));
        end else if (load_en) begin
            ptr_d = load_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            addr_q <= '0;
        end else begin
            ptr_q  <= ptr_d;
            addr_q <= addr_d;
        end
    end
endmodule

// File: rtl/tblx_latch.sv
module tblx_latch
    import tblx_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  logic [DW-1:0] rdata,
    input  logic          load_en,
    input  logic [DW-1:0] load_val,
    output logic [DW-1:0] lat_q
);
    always_ff @(posedge clk) begin
        if (rst)          lat_q <= '0;
        else if (capture) lat_q <= rdata;
        else if (load_en) lat_q <= load_val;
    end
endmodule

// File: rtl/tblx_unit.sv
module tblx_unit
    import tblx_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic          cmd_write,
    input  logic [1:0]    cmd_mode,
    input  logic          ptr_load,
    input  logic [AW-1:0] ptr_load_val,
    input  logic          lat_load,
    input  logic [DW-1:0] lat_load_val,
    output logic [AW-1:0] ptr_o,
    output logic [DW-1:0] lat_o,
    output logic          busy,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack
);
    logic accept, done, issue, quiet;
    cmd_t cmd_q;

    tblx_seq u_seq (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_mode(cmd_mode),
        .mem_ack(mem_ack),
        .accept(accept), .done(done), .busy(busy), .issue(issue), .cmd_q(cmd_q)
    );

    // Loads only land on a cycle with no access and no new command.
    assign quiet = !busy && !cmd_valid;

    tblx_ptr #(.AW(AW)) u_ptr (
        .clk(clk), .rst(rst),
        .accept(accept), .acc_mode(cmd_mode),
        .done(done), .held_mode(cmd_q.mode),
        .load_en(quiet && ptr_load), .load_val(ptr_load_val),
        .ptr_q(ptr_o), .addr_q(mem_addr)
    );

    tblx_latch #(.DW(DW)) u_lat (
        .clk(clk), .rst(rst),
        .capture(done && !cmd_q.write), .rdata(mem_rdata),
        .load_en(quiet && lat_load), .load_val(lat_load_val),
        .lat_q(lat_o)
    );

    assign mem_req   = issue;
    assign mem_we    = busy && cmd_q.write;
    assign mem_wdata = lat_o;
endmodule

// File: rtl/tblx_unit_chk.sv
module tblx_unit_chk
    import tblx_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          mem_req,
    input logic          mem_ack,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [AW-1:0] ptr_o,
    input logic [DW-1:0] lat_o,
    input cmd_t          cmd_q
);
    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req); // R2
    AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy); // R2
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && !mem_ack) |=> $stable(mem_addr)); // R2
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && !mem_ack) |=> $stable(ptr_o)); // R11
    AST_WRITE_KEEPS_LAT: assert property (@(posedge clk) disable iff (rst)
        (busy && mem_we) |=> $stable(lat_o)); // R4
    AST_POSTINC_STEP: assert property (@(posedge clk) disable iff (rst)
        (busy && mem_ack && cmd_q.mode == UPD_POSTINC) |=> ptr_o == AW'($past(mem_addr) + AW'(1))); // R6
    AST_POSTDEC_STEP: assert property (@(posedge clk) disable iff (rst)
        (busy && mem_ack && cmd_q.mode == UPD_POSTDEC) |=> ptr_o == AW'($past(mem_addr) - AW'(1))); // R7
    AST_PREINC_ADDR: assert property (@(posedge clk) disable iff (rst)
        (mem_req && cmd_q.mode == UPD_PREINC) |-> mem_addr == ptr_o); // R8
    AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (rst)
        (busy && mem_ack) |=> !busy); // R3
endmodule

bind tblx_unit tblx_unit_chk #(.AW(AW), .DW(DW)) chk_i (
    .clk(clk), .rst(rst), .busy(busy), .mem_req(mem_req), .mem_ack(mem_ack),
    .mem_we(mem_we), .mem_addr(mem_addr), .ptr_o(ptr_o), .lat_o(lat_o),
    .cmd_q(cmd_q)
);

// File: tb/tblx_unit_tb_top.sv
module tblx_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0, cmd_write = 1'b0;
    logic [1:0]  cmd_mode = 2'b00;
    logic        ptr_load = 1'b0, lat_load = 1'b0;
    logic [20:0] ptr_load_val = '0;
    logic [7:0]  lat_load_val = '0;
    logic [20:0] ptr_o, mem_addr;
    logic [7:0]  lat_o, mem_wdata;
    logic        busy, mem_req, mem_we;
    logic [7:0]  mem_rdata = '0;
    logic        mem_ack = 1'b0;

    int n_chk = 0, n_bad = 0;
    logic [20:0] ptr_m = '0;
    logic [7:0]  lat_m = '0;

    always #2 clk = ~clk;

    tblx_unit dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_mode(cmd_mode), .ptr_load(ptr_load), .ptr_load_val(ptr_load_val),
        .lat_load(lat_load), .lat_load_val(lat_load_val), .ptr_o(ptr_o),
        .lat_o(lat_o), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack)
    );

    function automatic logic [7:0] rd_of(input logic [20:0] a);
        return a[7:0] ^ a[20:13] ^ 8'h5A;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_load(input logic [20:0] p, input logic [7:0] l);
        @(negedge clk);
        ptr_load = 1'b1; ptr_load_val = p; lat_load = 1'b1; lat_load_val = l;
        @(negedge clk);
        ptr_load = 1'b0; lat_load = 1'b0;
        ptr_m = p; lat_m = l;
        check("R10 ptr load", 32'(ptr_o), 32'(p));
        check("R10 lat load", 32'(lat_o), 32'(l));
    endtask

    // One access; waits >= 1 cycles between request and acknowledge.
    task automatic do_access(input string tag, input bit wr, input logic [1:0] md, input int waits);
        logic [20:0] exp_addr, exp_ptr;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_write = wr; cmd_mode = md;
        @(negedge clk);
        cmd_valid = 1'b0;
        exp_addr = (md == 2'b11) ? ptr_m + 21'd1 : ptr_m;
        check({tag, " R2 busy"}, 32'(busy), 32'd1);
        check({tag, " R2 req"}, 32'(mem_req), 32'd1);
        check({tag, " addr"}, 32'(mem_addr), 32'(exp_addr));
        check({tag, " R4 we"}, 32'(mem_we), 32'(wr));
        if (wr) check({tag, " R4 wdata"}, 32'(mem_wdata), 32'(lat_m));
        if (md == 2'b11) check({tag, " R8 early ptr"}, 32'(ptr_o), 32'(exp_addr));
        for (int i = 0; i < waits; i++) begin
            @(negedge clk);
            check({tag, " R11 busy held"}, 32'(busy), 32'd1);
            check({tag, " R2 req single"}, 32'(mem_req), 32'd0);
            check({tag, " R2 addr stable"}, 32'(mem_addr), 32'(exp_addr));
        end
        mem_ack = 1'b1; mem_rdata = rd_of(mem_addr);
        @(negedge clk);
        mem_ack = 1'b0;
        case (md)
            2'b01:   exp_ptr = exp_addr + 21'd1;
            2'b10:   exp_ptr = exp_addr - 21'd1;
            default: exp_ptr = exp_addr;
        endcase
        if (!wr) lat_m = rd_of(exp_addr);
        ptr_m = exp_ptr;
        check({tag, " R3 busy drops"}, 32'(busy), 32'd0);
        check({tag, " ptr after"}, 32'(ptr_o), 32'(exp_ptr));
        check({tag, wr ? " R4 latch kept" : " R3 latch read"}, 32'(lat_o), 32'(lat_m));
    endtask

    task automatic test_reset();
        check("R1 ptr", 32'(ptr_o), 32'd0);
        check("R1 lat", 32'(lat_o), 32'd0);
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 req", 32'(mem_req), 32'd0);
        check("R1 we", 32'(mem_we), 32'd0);
    endtask

    task automatic test_modes();
        do_load(21'h01234, 8'hC3);
        do_access("R5 keep rd", 1'b0, 2'b00, 1);
        do_access("R6 postinc rd", 1'b0, 2'b01, 2);
        do_access("R7 postdec wr", 1'b1, 2'b10, 1);
        do_access("R8 preinc rd", 1'b0, 2'b11, 3);
        do_access("R4 keep wr", 1'b1, 2'b00, 1);
        do_access("R8 preinc wr", 1'b1, 2'b11, 1);
    endtask

    task automatic test_wrap();
        do_load(21'h1FFFFF, 8'h11);
        do_access("R9 postinc wrap", 1'b0, 2'b01, 1);
        check("R9 wrapped to zero", 32'(ptr_o), 32'd0);
        do_access("R9 postdec wrap", 1'b1, 2'b10, 1);
        check("R9 wrapped to top", 32'(ptr_o), 32'h1FFFFF);
        do_access("R9 preinc wrap", 1'b0, 2'b11, 1);
        check("R9 preinc to zero", 32'(ptr_o), 32'd0);
    endtask

    task automatic test_ignore();
        do_load(21'h00400, 8'h77);
        // Command beats a same-cycle load.
        @(negedge clk);
        cmd_valid = 1'b1; cmd_write = 1'b1; cmd_mode = 2'b00;
        ptr_load = 1'b1; ptr_load_val = 21'h0BEEF; lat_load = 1'b1; lat_load_val = 8'hEE;
        @(negedge clk);
        cmd_valid = 1'b0; ptr_load = 1'b0; lat_load = 1'b0;
        check("R10 cmd wins addr", 32'(mem_addr), 32'h00400);
        check("R10 cmd wins ptr", 32'(ptr_o), 32'h00400);
        check("R10 cmd wins wdata", 32'(mem_wdata), 32'h77);
        // While busy: loads and commands are dropped.
        @(negedge clk);
        cmd_valid = 1'b1; cmd_write = 1'b0; cmd_mode = 2'b01;
        ptr_load = 1'b1; ptr_load_val = 21'h0F00D; lat_load = 1'b1; lat_load_val = 8'h99;
        @(negedge clk);
        cmd_valid = 1'b0; ptr_load = 1'b0; lat_load = 1'b0;
        check("R11 busy ptr untouched", 32'(ptr_o), 32'h00400);
        check("R11 busy lat untouched", 32'(lat_o), 32'h77);
        check("R11 no second req", 32'(mem_req), 32'd0);
        mem_ack = 1'b1; mem_rdata = 8'hAB;
        @(negedge clk);
        mem_ack = 1'b0;
        check("R10 write done lat", 32'(lat_o), 32'h77);
        check("R10 write done ptr", 32'(ptr_o), 32'h00400);
        @(negedge clk);
        check("R11 dropped cmd no busy", 32'(busy), 32'd0);
        check("R11 dropped cmd no req", 32'(mem_req), 32'd0);
        // Stray acknowledge while idle.
        mem_ack = 1'b1; mem_rdata = 8'h3C;
        @(negedge clk);
        mem_ack = 1'b0;
        check("R11 idle ack lat", 32'(lat_o), 32'h77);
        check("R11 idle ack busy", 32'(busy), 32'd0);
        ptr_m = 21'h00400; lat_m = 8'h77;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_modes();
        test_wrap();
        test_ignore();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule